// File: doc/BRIEF.md
# Privilege-Level Trace Register Access Trap Resolver

This block decides what happens when software tries to read or write a protected trace control register. It takes the privilege level of the attempt (0 to 3) and whether the access is a read or a write. It also takes which higher levels exist, whether level 2 is enabled, the trap-control bits that levels 1, 2 and 3 hold, a fine-grained read/write trap pair with its enables, and the terms of an external-debug halt request. From these it produces exactly one outcome: the access is undefined, it traps to level 1, 2 or 3 with a fixed syndrome class, it requests a debug halt, or it is granted.

The decision is a fixed, level-dependent priority chain. The chain that applies is chosen by the privilege level of the attempt (PL0, PL1, PL2, PL3), and each rule along it yields one of four verdicts: UNDEF, TRAP, HALT, GRANT. The core is purely combinational. A parameter `OUT_REG` adds one output register stage. While reset is applied that stage holds the UNDEF verdict, and it presents each decision one clock after its inputs.

Top module: `trap_resolver`

## Requirements
- R1: An attempt from privilege level 0 (`cur_lvl` = 0) always yields undefined, whatever the other inputs are.
- R2: Exactly one of `out_undef`, `out_trap`, `out_halt`, `out_grant` is high. With `out_trap` high, `trap_lvl` holds the target level (1, 2 or 3) and `trap_class` holds `CLASS_CODE` (default 8'h18). With `out_trap` low, both fields are zero.
- R3: At level 1 the first matching rule wins, in this order. (a) Level 3 exists, its trap bit is set and the undefined-priority condition holds: undefined. (b) The level-1 trap bit is set: trap to 1. (c) Level 2 is enabled (`has_lvl2` and `lvl2_on` both high) and its trap bit is set: trap to 2. (d) The fine-grained trap of R4 applies: trap to 2. (e) Level 3 exists and its trap bit is set: undefined if `sdd_undef` is high, otherwise trap to 3. (f) The halt condition of R7 holds: halt. (g) Otherwise: granted.
- R4: The fine-grained trap applies only when level 2 is enabled, `fg_feature` is high, level 3 is absent or `l3_fg_en` is high, and the trap bit for the access direction is set. Reads (`is_write` = 0) use `fg_rd_trap` and writes use `fg_wr_trap`.
- R5: At level 2 the first matching rule wins, in this order. (a) Level 3 exists with its trap bit and the undefined-priority condition: undefined. (b) The level-2 trap bit is set: trap to 2. (c) Level 3 exists with its trap bit: undefined if `sdd_undef` is high, otherwise trap to 3. (d) The halt condition holds and `l1_a32` is low: halt. (e) Otherwise: granted.
- R6: At level 3 the first matching rule wins, in this order. (a) Level 3 exists with its trap bit: trap to 3. (b) The halt condition holds and `l1_a32` is low: halt. (c) Otherwise: granted.
- R7: The halt condition requires all four of `tbuf_feature` high, `os_lock` low, `halt_ok` high and `ext_dbg_trap` high. If any one is missing, the access falls through to granted.
- R8: When `has_lvl3` is low, every check that involves level 3 is skipped. No outcome is a trap to level 3, and neither `undef_prio` nor `sdd_undef` has any effect.
- R9: With `OUT_REG` = 1, the outputs present the decision for the inputs sampled at the previous rising clock edge. While `rst_n` is low they show undefined, with `trap_lvl` and `trap_class` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| cur_lvl | input | 2 | Privilege level of the access attempt |
| is_write | input | 1 | 1 = write access, 0 = read access |
| has_lvl2 | input | 1 | Level 2 is implemented |
| has_lvl3 | input | 1 | Level 3 is implemented |
| lvl2_on | input | 1 | Level 2 is enabled for the current context |
| undef_prio | input | 1 | Level-3 trap is reported as undefined with top priority |
| sdd_undef | input | 1 | Level-3 trap is turned into undefined (secure debug disabled) |
| l1_trap_bit | input | 1 | Trap-to-level-1 control bit |
| l2_trap_bit | input | 1 | Trap-to-level-2 control bit |
| l3_trap_bit | input | 1 | Trap-to-level-3 control bit |
| fg_feature | input | 1 | Fine-grained trap feature is implemented |
| l3_fg_en | input | 1 | Level 3 permits fine-grained traps |
| fg_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fg_wr_trap | input | 1 | Fine-grained trap bit for writes |
| tbuf_feature | input | 1 | External trace buffer feature is implemented |
| os_lock | input | 1 | OS lock is set |
| halt_ok | input | 1 | Halting is allowed |
| ext_dbg_trap | input | 1 | External debugger trap bit |
| l1_a32 | input | 1 | Level 1 runs in the 32-bit state |
| out_undef | output | 1 | Outcome: undefined |
| out_trap | output | 1 | Outcome: trap |
| out_halt | output | 1 | Outcome: debug halt |
| out_grant | output | 1 | Outcome: access granted |
| trap_lvl | output | 2 | Trap target level, zero when not trapping |
| trap_class | output | 8 | Syndrome class, zero when not trapping |

## Verification
The only state is the optional output register, so a wrong priority or a wrong condition term shows at the ports as a different one-hot outcome or a different trap level. In the combinational variant it shows in the same cycle as the input pattern, and in the registered variant one clock later. A stuck or mis-reset output register shows as a broken one-hot code or a stale verdict on the first cycle after reset. Sweeping many input patterns across all four levels, with trap bits biased low so that the deep rules are reached, exposes a swap of any two adjacent rules.

// File: rtl/trap_res_pkg.sv
package trap_res_pkg;

    typedef enum logic [1:0] {
        PL0 = 2'd0,
        PL1 = 2'd1,
        PL2 = 2'd2,
        PL3 = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        VD_UNDEF = 2'd0,
        VD_TRAP  = 2'd1,
        VD_HALT  = 2'd2,
        VD_GRANT = 2'd3
    } verdict_e;

    localparam int unsigned LVL_W = 2;

    typedef struct packed {
        verdict_e         kind;
        logic [LVL_W-1:0] target;
    } decision_t;

endpackage

// File: rtl/trap_res_halt.sv
module trap_res_halt (
    input  logic tbuf_feature,
    input  logic os_lock,
    input  logic halt_ok,
    input  logic ext_dbg_trap,
    output logic halt_req
);
    always_comb begin
        halt_req = tbuf_feature && !os_lock && halt_ok && ext_dbg_trap;
    end
endmodule

// File: rtl/trap_res_fgt.sv
module trap_res_fgt (
    input  logic l2_en,
    input  logic has_lvl3,
    input  logic fg_feature,
    input  logic l3_fg_en,
    input  logic is_write,
    input  logic fg_rd_trap,
    input  logic fg_wr_trap,
    output logic fg_hit
);
    logic dir_bit;
    logic gate_ok;

    always_comb begin
        dir_bit = is_write ? fg_wr_trap : fg_rd_trap;
        gate_ok = l2_en && fg_feature && (!has_lvl3 || l3_fg_en);
        fg_hit  = gate_ok && dir_bit;
    end
endmodule

// File: rtl/trap_res_rank.sv
module trap_res_rank
    import trap_res_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             has_lvl3,
    input  logic             l2_en,
    input  logic             undef_prio,
    input  logic             sdd_undef,
    input  logic             l1_trap_bit,
    input  logic             l2_trap_bit,
    input  logic             l3_trap_bit,
    input  logic             fg_hit,
    input  logic             halt_req,
    input  logic             l1_a32,
    output decision_t        dec
);
    priv_e lvl;
    logic  l3_armed;
    logic  l3_first;
    logic  halt_hi;

    localparam logic [LVL_W-1:0] TGT_NONE = '0;
    localparam logic [LVL_W-1:0] TGT_L1   = LVL_W'(1);
    localparam logic [LVL_W-1:0] TGT_L2   = LVL_W'(2);
    localparam logic [LVL_W-1:0] TGT_L3   = LVL_W'(3);

    always_comb begin
        lvl      = priv_e'(cur_lvl);
        l3_armed = has_lvl3 && l3_trap_bit;
        l3_first = l3_armed && undef_prio;
        halt_hi  = halt_req && !l1_a32;
        dec      = '{kind: VD_GRANT, target: TGT_NONE};

        unique case (lvl)
            PL0: begin
                dec = '{kind: VD_UNDEF, target: TGT_NONE};
            end
            PL1: begin
                if (l3_first)
                    dec = '{kind: VD_UNDEF, target: TGT_NONE};
                else if (l1_trap_bit)
                    dec = '{kind: VD_TRAP, target: TGT_L1};
                else if (l2_en && l2_trap_bit)
                    dec = '{kind: VD_TRAP, target: TGT_L2};
                else if (fg_hit)
                    dec = '{kind: VD_TRAP, target: TGT_L2};
                else if (l3_armed)
                    dec = sdd_undef ? '{kind: VD_UNDEF, target: TGT_NONE}
                                    : '{kind: VD_TRAP,  target: TGT_L3};
                else if (halt_req)
                    dec = '{kind: VD_HALT, target: TGT_NONE};
                else
                    dec = '{kind: VD_GRANT, target: TGT_NONE};
            end
            PL2: begin
                if (l3_first)
                    dec = '{kind: VD_UNDEF, target: TGT_NONE};
                else if (l2_trap_bit)
                    dec = '{kind: VD_TRAP, target: TGT_L2};
                else if (l3_armed)
                    dec = sdd_undef ? '{kind: VD_UNDEF, target: TGT_NONE}
                                    : '{kind: VD_TRAP,  target: TGT_L3};
                else if (halt_hi)
                    dec = '{kind: VD_HALT, target: TGT_NONE};
                else
                    dec = '{kind: VD_GRANT, target: TGT_NONE};
            end
            PL3: begin
                if (l3_armed)
                    dec = '{kind: VD_TRAP, target: TGT_L3};
                else if (halt_hi)
                    dec = '{kind: VD_HALT, target: TGT_NONE};
                else
                    dec = '{kind: VD_GRANT, target: TGT_NONE};
            end
            default: begin
                dec = '{kind: VD_UNDEF, target: TGT_NONE};
            end
        endcase
    end
endmodule

// File: rtl/trap_res_outstage.sv
module trap_res_outstage
    import trap_res_pkg::*;
#(
    parameter bit              OUT_REG    = 1'b0,
    parameter int unsigned     CLASS_W    = 8,
    parameter logic [CLASS_W-1:0] CLASS_CODE = CLASS_W'(8'h18)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  decision_t          dec,
    output logic               out_undef,
    output logic               out_trap,
    output logic               out_halt,
    output logic               out_grant,
    output logic [LVL_W-1:0]   trap_lvl,
    output logic [CLASS_W-1:0] trap_class
);
    localparam int unsigned PACK_W = 4 + LVL_W + CLASS_W;

    logic [PACK_W-1:0] pack_d;
    logic [PACK_W-1:0] pack_q;

    always_comb begin
        pack_d = '0;
        unique case (dec.kind)
            VD_UNDEF: pack_d[PACK_W-1] = 1'b1;
            VD_TRAP: begin
                pack_d[PACK_W-2]                = 1'b1;
                pack_d[LVL_W+CLASS_W-1:CLASS_W] = dec.target;
                pack_d[CLASS_W-1:0]             = CLASS_CODE;
            end
            VD_HALT:  pack_d[PACK_W-3] = 1'b1;
            VD_GRANT: pack_d[PACK_W-4] = 1'b1;
            default:  pack_d[PACK_W-1] = 1'b1;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            localparam logic [PACK_W-1:0] RST_PACK = {1'b1, {(PACK_W-1){1'b0}}};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pack_q <= RST_PACK;
                else        pack_q <= pack_d;
            end
        end else begin : g_comb
            always_comb pack_q = pack_d;
        end
    endgenerate

    always_comb begin
        {out_undef, out_trap, out_halt, out_grant, trap_lvl, trap_class} = pack_q;
    end

    // R2
    onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_undef, out_trap, out_halt, out_grant}) == 1);

    // R2
    idle_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_trap |-> (trap_lvl == '0 && trap_class == '0));

    // R2
    trap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (trap_lvl != '0 && trap_class == CLASS_CODE));
endmodule

// File: rtl/trap_resolver.sv
module trap_resolver
    import trap_res_pkg::*;
#(
    parameter bit                 OUT_REG    = 1'b0,
    parameter int unsigned        CLASS_W    = 8,
    parameter logic [CLASS_W-1:0] CLASS_CODE = CLASS_W'(8'h18)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cur_lvl,
    input  logic               is_write,
    input  logic               has_lvl2,
    input  logic               has_lvl3,
    input  logic               lvl2_on,
    input  logic               undef_prio,
    input  logic               sdd_undef,
    input  logic               l1_trap_bit,
    input  logic               l2_trap_bit,
    input  logic               l3_trap_bit,
    input  logic               fg_feature,
    input  logic               l3_fg_en,
    input  logic               fg_rd_trap,
    input  logic               fg_wr_trap,
    input  logic               tbuf_feature,
    input  logic               os_lock,
    input  logic               halt_ok,
    input  logic               ext_dbg_trap,
    input  logic               l1_a32,
    output logic               out_undef,
    output logic               out_trap,
    output logic               out_halt,
    output logic               out_grant,
    output logic [1:0]         trap_lvl,
    output logic [CLASS_W-1:0] trap_class
);
    logic      l2_en;
    logic      fg_hit;
    logic      halt_req;
    decision_t dec;

    always_comb l2_en = has_lvl2 && lvl2_on;

    trap_res_halt u_halt (
        .tbuf_feature (tbuf_feature),
        .os_lock      (os_lock),
        .halt_ok      (halt_ok),
        .ext_dbg_trap (ext_dbg_trap),
        .halt_req     (halt_req)
    );

    trap_res_fgt u_fgt (
        .l2_en      (l2_en),
        .has_lvl3   (has_lvl3),
        .fg_feature (fg_feature),
        .l3_fg_en   (l3_fg_en),
        .is_write   (is_write),
        .fg_rd_trap (fg_rd_trap),
        .fg_wr_trap (fg_wr_trap),
        .fg_hit     (fg_hit)
    );

    trap_res_rank u_rank (
        .cur_lvl     (cur_lvl),
        .has_lvl3    (has_lvl3),
        .l2_en       (l2_en),
        .undef_prio  (undef_prio),
        .sdd_undef   (sdd_undef),
        .l1_trap_bit (l1_trap_bit),
        .l2_trap_bit (l2_trap_bit),
        .l3_trap_bit (l3_trap_bit),
        .fg_hit      (fg_hit),
        .halt_req    (halt_req),
        .l1_a32      (l1_a32),
        .dec         (dec)
    );

    trap_res_outstage #(
        .OUT_REG    (OUT_REG),
        .CLASS_W    (CLASS_W),
        .CLASS_CODE (CLASS_CODE)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .out_undef  (out_undef),
        .out_trap   (out_trap),
        .out_halt   (out_halt),
        .out_grant  (out_grant),
        .trap_lvl   (trap_lvl),
        .trap_class (trap_class)
    );

    generate
        if (OUT_REG) begin : g_chk_q
            // R1
            l0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_lvl == 2'd0) |=> out_undef);
            // R6
            l3_own_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_lvl == 2'd3 && has_lvl3 && l3_trap_bit) |=> (out_trap && trap_lvl == 2'd3));
            // R8
            absent_l3_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !has_lvl3 |=> !(out_trap && trap_lvl == 2'd3));
            // R3
            l1_own_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_lvl == 2'd1 && l1_trap_bit && !(has_lvl3 && l3_trap_bit && undef_prio))
                |=> (out_trap && trap_lvl == 2'd1));
        end else begin : g_chk_c
            // R1
            l0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_lvl == 2'd0) |-> out_undef);
            // R6
            l3_own_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_lvl == 2'd3 && has_lvl3 && l3_trap_bit) |-> (out_trap && trap_lvl == 2'd3));
            // R8
            absent_l3_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !has_lvl3 |-> !(out_trap && trap_lvl == 2'd3));
            // R3
            l1_own_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cur_lvl == 2'd1 && l1_trap_bit && !(has_lvl3 && l3_trap_bit && undef_prio))
                |-> (out_trap && trap_lvl == 2'd1));
        end
    endgenerate
endmodule

// File: tb/test_trap_resolver.sv
module test_trap_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int N_SWEEP    = 60000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [19:0] vin = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic uc, tc, hc, gc, uq, tq, hq, gq;
    logic [1:0] lc, lq;
    logic [7:0] cc, cq;

    trap_resolver #(.OUT_REG(1'b0)) i_trap_resolver (
        .clk(clk), .rst_n(rst_n), .cur_lvl(vin[1:0]), .is_write(vin[2]),
        .has_lvl2(vin[3]), .has_lvl3(vin[4]), .lvl2_on(vin[5]), .undef_prio(vin[6]),
        .sdd_undef(vin[7]), .l1_trap_bit(vin[8]), .l2_trap_bit(vin[9]), .l3_trap_bit(vin[10]),
        .fg_feature(vin[11]), .l3_fg_en(vin[12]), .fg_rd_trap(vin[13]), .fg_wr_trap(vin[14]),
        .tbuf_feature(vin[15]), .os_lock(vin[16]), .halt_ok(vin[17]), .ext_dbg_trap(vin[18]),
        .l1_a32(vin[19]), .out_undef(uc), .out_trap(tc), .out_halt(hc), .out_grant(gc),
        .trap_lvl(lc), .trap_class(cc));

    trap_resolver #(.OUT_REG(1'b1)) i_trap_resolver_q (
        .clk(clk), .rst_n(rst_n), .cur_lvl(vin[1:0]), .is_write(vin[2]),
        .has_lvl2(vin[3]), .has_lvl3(vin[4]), .lvl2_on(vin[5]), .undef_prio(vin[6]),
        .sdd_undef(vin[7]), .l1_trap_bit(vin[8]), .l2_trap_bit(vin[9]), .l3_trap_bit(vin[10]),
        .fg_feature(vin[11]), .l3_fg_en(vin[12]), .fg_rd_trap(vin[13]), .fg_wr_trap(vin[14]),
        .tbuf_feature(vin[15]), .os_lock(vin[16]), .halt_ok(vin[17]), .ext_dbg_trap(vin[18]),
        .l1_a32(vin[19]), .out_undef(uq), .out_trap(tq), .out_halt(hq), .out_grant(gq),
        .trap_lvl(lq), .trap_class(cq));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Packed result: {undef, trap, halt, grant, lvl[1:0], class[7:0]}
    localparam logic [13:0] E_UNDEF = 14'b1000_00_00000000;
    localparam logic [13:0] E_HALT  = 14'b0010_00_00000000;
    localparam logic [13:0] E_GRANT = 14'b0001_00_00000000;

    function automatic logic [13:0] e_trap(input int lv);
        return {4'b0100, 2'(lv), 8'h18};
    endfunction

    function automatic logic [13:0] model(input logic [19:0] v, output string tag);
        int  lv   = int'(v[1:0]);
        bit  wr   = v[2],  h2 = v[3], h3 = v[4], on2 = v[5], up = v[6], sd = v[7];
        bit  t1   = v[8],  t2 = v[9], t3 = v[10];
        bit  ff   = v[11], fe3 = v[12], frd = v[13], fwr = v[14];
        bit  halt = v[15] & ~v[16] & v[17] & v[18];
        bit  a32  = v[19];
        bit  en2  = h2 & on2;
        bit  x3   = h3 & t3;
        bit  fg   = en2 & ff & (~h3 | fe3) & (wr ? fwr : frd);
        if (lv == 0) begin tag = "R1"; return E_UNDEF; end
        if (lv == 3) begin
            if (x3)          begin tag = "R6"; return e_trap(3); end
            if (halt & ~a32) begin tag = "R7"; return E_HALT; end
            tag = "R6"; return E_GRANT;
        end
        if (x3 & up) begin tag = (lv == 1) ? "R3" : "R5"; return E_UNDEF; end
        if (lv == 1) begin
            if (t1)        begin tag = "R3"; return e_trap(1); end
            if (en2 & t2)  begin tag = "R3"; return e_trap(2); end
            if (fg)        begin tag = "R4"; return e_trap(2); end
            if (x3)        begin tag = "R3"; return sd ? E_UNDEF : e_trap(3); end
            if (halt)      begin tag = "R7"; return E_HALT; end
            tag = h3 ? "R3" : "R8"; return E_GRANT;
        end
        if (t2)          begin tag = "R5"; return e_trap(2); end
        if (x3)          begin tag = "R5"; return sd ? E_UNDEF : e_trap(3); end
        if (halt & ~a32) begin tag = "R7"; return E_HALT; end
        tag = "R5"; return E_GRANT;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    logic [13:0] prev_exp;
    string       prev_tag;
    bit          have_prev = 1'b0;

    task automatic run_vec(input logic [19:0] v, input string force_tag);
        string t;
        logic [13:0] e;
        @(negedge clk);
        if (have_prev) check({prev_tag, "/R9"}, "registered", {uq, tq, hq, gq, lq, cq}, prev_exp);
        vin = v;
        #1;
        e = model(v, t);
        if (force_tag != "") t = force_tag;
        check({t, "/R2"}, "comb", {uc, tc, hc, gc, lc, cc}, e);
        prev_exp  = e;
        prev_tag  = t;
        have_prev = 1'b1;
    endtask

    initial begin
        logic [31:0] s = 32'h1234_5678;
        logic [31:0] a, b;
        logic [19:0] v;
        vin = '0;
        repeat (3) @(negedge clk);
        // R9: reset state of the registered variant
        check("R9", "reset", {uq, tq, hq, gq, lq, cq}, E_UNDEF);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: level 0 with a grant-looking setup
        run_vec({1'b0, 4'b1010, 4'b0000, 3'b000, 5'b00000, 1'b0, 2'd0}, "R1");
        // R4: read uses fg_rd_trap, write uses fg_wr_trap (h2,on2,ff set, lvl 1)
        run_vec(20'h0_2828 | 20'h0_0001, "R4");
        run_vec(20'h0_4828 | 20'h0_0005, "R4");
        run_vec(20'h0_4828 | 20'h0_0001, "R4");
        // R7: halt at level 2 blocked by l1_a32, allowed at level 1
        run_vec(20'hE_8002, "R7");
        run_vec(20'h6_8002, "R7");
        run_vec(20'h6_8001, "R7");
        // R7: os_lock set blocks halt
        run_vec(20'h7_8001, "R7");
        // R8: no level 3, l3 trap/undef_prio/sdd_undef have no effect
        run_vec(20'h0_04C1, "R8");
        run_vec(20'h0_04C3, "R8");
        run_vec(20'h0_04C2, "R8");
        // Sweep, trap bits biased low so the deep rules are reached
        for (int n = 0; n < N_SWEEP; n++) begin
            s = s * 32'd1103515245 + 32'd12345;  a = s;
            s = s * 32'd1103515245 + 32'd12345;  b = s;
            v = a[31:12];
            v[6]  = a[6]  & b[6];
            v[8]  = a[8]  & b[8];
            v[9]  = a[9]  & b[9];
            v[10] = a[10] & b[10];
            v[13] = a[13] & b[13];
            v[14] = a[14] & b[14];
            v[15] = a[15] | b[15];
            v[16] = a[16] & b[16];
            v[17] = a[17] | b[17];
            v[18] = a[18] | b[18];
            v[1:0] = b[21:20];
            run_vec(v, "");
        end
        @(negedge clk);
        check({prev_tag, "/R9"}, "registered", {uq, tq, hq, gq, lq, cq}, prev_exp);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 180000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule